// File: doc/BRIEF.md
# Fan Tachometer Period Capture

This block measures the speed of up to several cooling fans from their tachometer outputs. A shared prescaler produces a sample tick once every `PRESCALE` clocks. With the default 8 MHz clock and a divide of 128, the tick runs at 62.5 kHz. For each channel, a period counter counts ticks between consecutive rising edges of the tachometer pin. When a period ends, the count is handed to a sequential divider. The divider turns the count into revolutions per minute using the number of tachometer pulses per fan revolution.

Each channel reads one of two candidate pins, A or B, chosen by a select bit. A channel publishes its raw period count and its speed together. At the same moment it sets a sticky valid flag, which the consumer clears by pulsing a write-one-to-clear input. A fan that stops is reported as zero speed. Once the period counter would pass its all-ones limit, the channel publishes a count of zero, and a zero count is converted to zero speed without any division.

Top module: `fan_tach_capture`

## Requirements
- R1: While and right after reset, `valid` is 0 and every `raw_count` and `rpm` field is 0.
- R2: A sample tick occurs once every `PRESCALE` clocks. A published raw count equals the number of ticks between two consecutive rising edges of the selected pin, within one tick.
- R3: A published speed equals floor(N / (P × count)), where N = 60 × (`CLK_HZ` / `PRESCALE`). P is the value of `ppr` bits [i×PPR_W +: PPR_W] for channel i, sampled when the conversion starts.
- R4: When the count is 0 or P is 0, the published speed is 0.
- R5: Suppose the period counter already holds all ones (2^CNT_W − 1) and one more tick arrives without an edge. The channel then publishes a raw count of 0 and a speed of 0, and sets valid. The next rising edge only restarts measurement and produces no sample.
- R6: `valid[i]` is set on every publication and stays set until `clr_valid[i]` is pulsed high, which clears it one clock later. A publication in the same cycle wins over the clear. `raw_count` and `rpm` change only on a publication.
- R7: `src_sel[i]` = 0 selects `tach_a[i]` and 1 selects `tach_b[i]`. The pin that is not selected has no effect. A change of `src_sel[i]` clears `valid[i]` on the next clock and discards the period and conversion in progress.
- R8: The first rising edge after reset or a restart only arms the channel; the earliest sample comes from the second edge.
- R9: Each channel measures, converts and flags independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_a | input | NUM_CH | Tachometer pin A of each channel (asynchronous) |
| tach_b | input | NUM_CH | Tachometer pin B of each channel (asynchronous) |
| src_sel | input | NUM_CH | Pin select per channel: 0 = A, 1 = B |
| ppr | input | NUM_CH×PPR_W | Pulses per revolution, one field per channel |
| clr_valid | input | NUM_CH | Write-one-to-clear pulse for each valid flag |
| valid | output | NUM_CH | Sticky new-sample flag per channel |
| raw_count | output | NUM_CH×CNT_W | Last published tick count per channel |
| rpm | output | NUM_CH×RPM_W | Last published speed per channel |

## Verification
A pin level driven before clock edge E0 is seen as a rising edge after E1 and captured at E2. The divider starts at E3 and, for a nonzero divisor, publishes count, speed and valid at edge E(RPM_W+4); a zero divisor publishes at E4. A cleared or re-selected flag drops one edge after the request. The bench drives inputs on falling edges. Rather than counting to a fixed cycle, it waits on `valid` with a bounded timeout, then samples on a falling edge. Clear and select checks read `valid` on the falling edge right after the clock edge that acts on them. Early-sample checks are placed well before the second tachometer edge could possibly publish.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int unsigned SECONDS_PER_MINUTE = 60;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    typedef enum logic {
        SRC_PIN_A = 1'b0,
        SRC_PIN_B = 1'b1
    } tach_src_e;

    // Constant numerator of the speed formula: 60 * sample rate.
    function automatic int unsigned rpm_numer(int unsigned clk_hz, int unsigned prescale);
        return SECONDS_PER_MINUTE * (clk_hz / prescale);
    endfunction

endpackage

// File: rtl/fan_tach_prescaler.sv
module fan_tach_prescaler #(
    parameter int PRESCALE = 128
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

    logic [PW-1:0] div_cnt;

    assign tick = (div_cnt == PW'(PRESCALE - 1));

    always_ff @(posedge clk) begin
        if (rst)       div_cnt <= '0;
        else if (tick) div_cnt <= '0;
        else           div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/fan_tach_channel.sv
module fan_tach_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic             tach_in,
    output logic             cap_stb,
    output logic [CNT_W-1:0] cap_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [2:0]       sync_q;
    logic             rise;
    logic             armed;
    logic [CNT_W-1:0] period_cnt;

    // Two synchronizer flops, third flop for edge detection.
    assign rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], tach_in};
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            armed      <= 1'b0;
            period_cnt <= '0;
            cap_stb    <= 1'b0;
            cap_cnt    <= '0;
        end else begin
            cap_stb <= 1'b0;
            if (rise) begin
                if (armed) begin
                    cap_stb <= 1'b1;
                    cap_cnt <= period_cnt;
                end
                armed      <= 1'b1;
                period_cnt <= '0;
            end else if (armed && tick) begin
                if (period_cnt == CNT_MAX) begin
                    // Stalled fan: report a zero count and wait for a fresh edge.
                    cap_stb <= 1'b1;
                    cap_cnt <= '0;
                    armed   <= 1'b0;
                end else begin
                    period_cnt <= period_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fan_rpm_divider.sv
module fan_rpm_divider
    import fan_tach_pkg::*;
#(
    parameter int unsigned NUMER = 3750000,
    parameter int          DEN_W = 20,
    parameter int          Q_W   = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             start,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [Q_W-1:0]   quo
);
    localparam int             IDX_W = $clog2(Q_W);
    localparam logic [Q_W-1:0] NUM_V = Q_W'(NUMER);

    div_state_e       state;
    logic [DEN_W-1:0] divisor;
    logic [DEN_W-1:0] rem;
    logic [IDX_W-1:0] bit_idx;
    logic [DEN_W:0]   trial;
    logic             fits;

    always_comb begin
        trial = {rem, NUM_V[bit_idx]};
        fits  = (trial >= {1'b0, divisor});
    end

    assign busy = (state == DIV_RUN);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state   <= DIV_IDLE;
            done    <= 1'b0;
            quo     <= '0;
            rem     <= '0;
            divisor <= '0;
            bit_idx <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                DIV_IDLE: begin
                    if (start) begin
                        if (den == '0) begin
                            quo  <= '0;
                            done <= 1'b1;
                        end else begin
                            state   <= DIV_RUN;
                            divisor <= den;
                            rem     <= '0;
                            quo     <= '0;
                            bit_idx <= IDX_W'(Q_W - 1);
                        end
                    end
                end
                DIV_RUN: begin
                    if (fits) begin
                        rem <= DEN_W'(trial - {1'b0, divisor});
                        quo <= {quo[Q_W-2:0], 1'b1};
                    end else begin
                        rem <= trial[DEN_W-1:0];
                        quo <= {quo[Q_W-2:0], 1'b0};
                    end
                    if (bit_idx == '0) begin
                        state <= DIV_IDLE;
                        done  <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx - 1'b1;
                    end
                end
                default: state <= DIV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fan_tach_capture.sv
module fan_tach_capture
    import fan_tach_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int CLK_HZ   = 8000000,
    parameter int PRESCALE = 128,
    parameter int CNT_W    = 16,
    parameter int PPR_W    = 4,
    localparam int unsigned NUMER = rpm_numer(CLK_HZ, PRESCALE),
    localparam int RPM_W   = $clog2(NUMER + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       tach_a,
    input  logic [NUM_CH-1:0]       tach_b,
    input  logic [NUM_CH-1:0]       src_sel,
    input  logic [NUM_CH*PPR_W-1:0] ppr,
    input  logic [NUM_CH-1:0]       clr_valid,
    output logic [NUM_CH-1:0]       valid,
    output logic [NUM_CH*CNT_W-1:0] raw_count,
    output logic [NUM_CH*RPM_W-1:0] rpm
);
    localparam int DEN_W = CNT_W + PPR_W;

    logic              tick;
    logic [NUM_CH-1:0] sel_q;
    logic [NUM_CH-1:0] restart;
    logic [NUM_CH-1:0] pub;

    fan_tach_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    always_ff @(posedge clk) sel_q <= src_sel;
    assign restart = src_sel ^ sel_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic             pin;
        logic             cap_stb;
        logic [CNT_W-1:0] cap_cnt;
        logic             start;
        logic [DEN_W-1:0] den;
        logic             busy;
        logic             done;
        logic [RPM_W-1:0] quo;
        logic [CNT_W-1:0] pend_cnt;
        logic             valid_q;
        logic [CNT_W-1:0] raw_q;
        logic [RPM_W-1:0] rpm_q;

        assign pin = (tach_src_e'(src_sel[g]) == SRC_PIN_B) ? tach_b[g] : tach_a[g];

        fan_tach_channel #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .restart (restart[g]),
            .tach_in (pin),
            .cap_stb (cap_stb),
            .cap_cnt (cap_cnt)
        );

        assign start = cap_stb & ~busy & ~restart[g];
        assign den   = DEN_W'(ppr[g*PPR_W +: PPR_W]) * DEN_W'(cap_cnt);

        always_ff @(posedge clk) begin
            if (rst)        pend_cnt <= '0;
            else if (start) pend_cnt <= cap_cnt;
        end

        fan_rpm_divider #(.NUMER(NUMER), .DEN_W(DEN_W), .Q_W(RPM_W)) u_div (
            .clk   (clk),
            .rst   (rst),
            .abort (restart[g]),
            .start (start),
            .den   (den),
            .busy  (busy),
            .done  (done),
            .quo   (quo)
        );

        assign pub[g] = done & ~restart[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= 1'b0;
                raw_q   <= '0;
                rpm_q   <= '0;
            end else if (restart[g]) begin
                valid_q <= 1'b0;
            end else if (pub[g]) begin
                valid_q <= 1'b1;
                raw_q   <= pend_cnt;
                rpm_q   <= quo;
            end else if (clr_valid[g]) begin
                valid_q <= 1'b0;
            end
        end

        assign valid[g]                  = valid_q;
        assign raw_count[g*CNT_W +: CNT_W] = raw_q;
        assign rpm[g*RPM_W +: RPM_W]     = rpm_q;
    end
endmodule

// File: rtl/fan_tach_capture_chk.sv
module fan_tach_capture_chk #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16,
    parameter int RPM_W  = 22
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_CH-1:0]       clr_valid,
    input logic [NUM_CH-1:0]       src_sel,
    input logic [NUM_CH-1:0]       valid,
    input logic [NUM_CH*CNT_W-1:0] raw_count,
    input logic [NUM_CH*RPM_W-1:0] rpm,
    input logic [NUM_CH-1:0]       pub
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        p_reset_state_r1: assert property (@(posedge clk)
            rst |=> (!valid[g] && raw_count[g*CNT_W +: CNT_W] == '0 && rpm[g*RPM_W +: RPM_W] == '0));

        p_zero_count_rpm_r4: assert property (@(posedge clk) disable iff (rst)
            (valid[g] && raw_count[g*CNT_W +: CNT_W] == '0) |-> (rpm[g*RPM_W +: RPM_W] == '0));

        p_clear_flag_r6: assert property (@(posedge clk) disable iff (rst)
            (clr_valid[g] && !pub[g]) |=> !valid[g]);

        p_hold_outputs_r6: assert property (@(posedge clk) disable iff (rst)
            !pub[g] |=> ($stable(raw_count[g*CNT_W +: CNT_W]) && $stable(rpm[g*RPM_W +: RPM_W])));

        p_select_change_r7: assert property (@(posedge clk) disable iff (rst)
            !$stable(src_sel[g]) |=> !valid[g]);
    end
endmodule

bind fan_tach_capture fan_tach_capture_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .RPM_W  (RPM_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_valid (clr_valid),
    .src_sel   (src_sel),
    .valid     (valid),
    .raw_count (raw_count),
    .rpm       (rpm),
    .pub       (pub)
);

// File: tb/fan_tach_capture_bench.sv
module fan_tach_capture_bench;
    localparam int NUM_CH   = 2;
    localparam int CLK_HZ   = 8000000;
    localparam int PRESCALE = 8;
    localparam int CNT_W    = 12;
    localparam int PPR_W    = 4;
    localparam longint NUMER = 60 * (CLK_HZ / PRESCALE);
    localparam int RPM_W    = $clog2(NUMER + 1);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    wire  [NUM_CH-1:0]       tach_a;
    wire  [NUM_CH-1:0]       tach_b;
    logic [NUM_CH-1:0]       src_sel = '0;
    logic [NUM_CH*PPR_W-1:0] ppr = '0;
    logic [NUM_CH-1:0]       clr_valid = '0;
    logic [NUM_CH-1:0]       valid;
    logic [NUM_CH*CNT_W-1:0] raw_count;
    logic [NUM_CH*RPM_W-1:0] rpm;

    int per_a [NUM_CH];
    int per_b [NUM_CH];
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fan_tach_capture #(
        .NUM_CH(NUM_CH), .CLK_HZ(CLK_HZ), .PRESCALE(PRESCALE),
        .CNT_W(CNT_W), .PPR_W(PPR_W)
    ) u_fan_tach_capture (
        .clk(clk), .rst(rst), .tach_a(tach_a), .tach_b(tach_b),
        .src_sel(src_sel), .ppr(ppr), .clr_valid(clr_valid),
        .valid(valid), .raw_count(raw_count), .rpm(rpm)
    );

    // Tachometer generators: period in clocks, 0 holds the pin low.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_gen
        logic ta = 1'b0;
        logic tb = 1'b0;
        assign tach_a[g] = ta;
        assign tach_b[g] = tb;
        initial forever begin
            @(negedge clk);
            if (per_a[g] > 0) begin
                ta = 1'b1; repeat (per_a[g] / 2) @(negedge clk);
                ta = 1'b0; repeat (per_a[g] - per_a[g] / 2 - 1) @(negedge clk);
            end
        end
        initial forever begin
            @(negedge clk);
            if (per_b[g] > 0) begin
                tb = 1'b1; repeat (per_b[g] / 2) @(negedge clk);
                tb = 1'b0; repeat (per_b[g] - per_b[g] / 2 - 1) @(negedge clk);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(string req, longint act, longint lo, longint hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    function automatic longint raw_of(int ch);
        return longint'(raw_count[ch*CNT_W +: CNT_W]);
    endfunction

    function automatic longint rpm_of(int ch);
        return longint'(rpm[ch*RPM_W +: RPM_W]);
    endfunction

    function automatic longint exp_rpm(longint cnt, longint p);
        if (cnt == 0 || p == 0) return 0;
        return NUMER / (p * cnt);
    endfunction

    task automatic wait_valid(int ch, int limit, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (valid[ch]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic pulse_clear(int ch);
        @(negedge clk); clr_valid[ch] = 1'b1;
        @(negedge clk); clr_valid[ch] = 1'b0;
    endtask

    task automatic fresh_sample(int ch, int limit, output bit ok);
        pulse_clear(ch);
        wait_valid(ch, limit, ok);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 valid in reset", longint'(valid), 0);
        check("R1 raw in reset", longint'(raw_count), 0);
        check("R1 rpm in reset", longint'(rpm), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_first_sample();
        bit ok;
        ppr[0*PPR_W +: PPR_W] = 4'd2;
        per_a[0] = 800;
        repeat (400) @(negedge clk);
        check("R8 no sample from first edge", longint'(valid[0]), 0);
        wait_valid(0, 2000, ok);
        check("R2 sample arrives", longint'(ok), 1);
        check_range("R2 raw count 100 ticks", raw_of(0), 99, 101);
        check("R3 rpm with P=2", rpm_of(0), exp_rpm(raw_of(0), 2));
    endtask

    task automatic t_clear();
        bit ok;
        longint r0;
        r0 = raw_of(0);
        pulse_clear(0);
        check("R6 valid cleared", longint'(valid[0]), 0);
        check("R6 raw held after clear", raw_of(0), r0);
        wait_valid(0, 2000, ok);
        check("R6 valid set again", longint'(ok), 1);
    endtask

    task automatic t_ppr_one();
        bit ok;
        ppr[0*PPR_W +: PPR_W] = 4'd1;
        fresh_sample(0, 2000, ok);
        fresh_sample(0, 2000, ok);
        check("R3 sample with P=1", longint'(ok), 1);
        check("R3 rpm with P=1", rpm_of(0), exp_rpm(raw_of(0), 1));
    endtask

    task automatic t_select();
        bit ok;
        per_b[0] = 1600;
        @(negedge clk); src_sel[0] = 1'b1;
        @(negedge clk);
        check("R7 select change clears valid", longint'(valid[0]), 0);
        wait_valid(0, 5000, ok);
        check("R7 sample from pin B", longint'(ok), 1);
        check_range("R7 pin A ignored, raw from B", raw_of(0), 199, 201);
    endtask

    task automatic t_stall();
        bit ok;
        per_b[0] = 0;
        repeat (2000) @(negedge clk);
        pulse_clear(0);
        wait_valid(0, 40000, ok);
        check("R5 stall publishes", longint'(ok), 1);
        check("R5 stall raw zero", raw_of(0), 0);
        check("R4 zero count gives zero rpm", rpm_of(0), 0);
        repeat (100) @(negedge clk);
        check("R6 valid sticky", longint'(valid[0]), 1);
        pulse_clear(0);
        per_b[0] = 1600;
        repeat (1000) @(negedge clk);
        check("R5 first edge after stall only arms", longint'(valid[0]), 0);
        wait_valid(0, 4000, ok);
        check_range("R5 restart after stall", raw_of(0), 199, 201);
    endtask

    task automatic t_second_channel();
        bit ok;
        check("R9 channel 1 untouched", longint'(valid[1]), 0);
        ppr[1*PPR_W +: PPR_W] = 4'd3;
        per_a[1] = 2400;
        wait_valid(1, 6000, ok);
        check("R9 channel 1 samples", longint'(ok), 1);
        check_range("R9 channel 1 raw 300", raw_of(1), 299, 301);
        check("R3 R9 channel 1 rpm P=3", rpm_of(1), exp_rpm(raw_of(1), 3));
        ppr[1*PPR_W +: PPR_W] = 4'd0;
        fresh_sample(1, 6000, ok);
        fresh_sample(1, 6000, ok);
        check_range("R4 raw with P=0", raw_of(1), 299, 301);
        check("R4 rpm with P=0", rpm_of(1), 0);
    endtask

    initial begin
        for (int i = 0; i < NUM_CH; i++) begin per_a[i] = 0; per_b[i] = 0; end
        t_reset();
        t_first_sample();
        t_clear();
        t_ppr_one();
        t_select();
        t_stall();
        t_second_channel();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule